// File: doc/BRIEF.md
# Flash Block Erase and Erase-Verify Sequencer

This controller carries a flash array through a complete erase of one or more blocks. After a start pulse it captures a mask of the blocks to erase and raises the software-write enable. It then handles the marked blocks one at a time. For each block it drives a one-hot select and brackets each erase pulse with the erase-setup strobe and a watchdog enable. After the pulse it switches the array into verify mode and walks every word of the block. For each word it makes a dummy write followed by a read, and it checks that the word reads back fully erased.

When a verify pass finds a word that is not fully erased, the sequencer sends the same block another erase pulse. It does this until an attempt limit is reached, and then it reports failure. Every strobe change is followed by a settling interval. The length of each interval is taken from a cycle-count input, so the same logic can serve any clock rate and any array timing. The block writes no zeros to a block before erasing it.

Top module: `flash_erase_seq`

## Requirements
- R1: On a start with a non-empty mask, `swe` is the first strobe to rise. Every step with a wait input W lasts max(W,1) cycles, and every other step lasts one cycle, before the next output change.
- R2: `blk_sel` has at most one bit set at any time. The blocks in the mask are each selected once, in ascending index order, and the selection is held from the select step until verify mode is cleared.
- R3: Each erase attempt runs in this order: `wdt_en` rises; `esu` rises and waits `t_esu_on`; `ers` rises and waits `t_pulse`; `ers` falls and waits `t_pulse_off`; `esu` falls and waits `t_esu_off`; `wdt_en` falls. `ers` is never high unless `esu`, `wdt_en` and `swe` are high and `ev` is low.
- R4: Verify mode raises `ev` and waits `t_ev_on`. Each word then gets a one-cycle `mem_we` with `mem_wdata` = 16'h00FF, a wait of `t_rd_settle`, and a one-cycle `mem_re`. Word addresses run from index*BLK_WORDS up to index*BLK_WORDS+BLK_WORDS-1.
- R5: A word passes only when `mem_rdata` is 16'hFFFF in the `mem_re` cycle. The first word that fails ends the verify pass at once.
- R6: Every verify pass ends with `ev` falling and a wait of `t_ev_off`. After a pass, the next block is selected, or the finish sequence starts if no block is left.
- R7: The attempt count starts at 1 for each block. After a failed verify with count n < `max_tries`, the count is incremented and the sequence goes back to the `wdt_en` step with the same block selected. When n >= `max_tries`, the run ends in failure. A value of 0 acts as 1.
- R8: Both outcomes end with `swe` falling, all selects cleared, and a wait of `t_swe_off`. Then comes a single-cycle `done` (success) or `fail` (attempts used up). The two are never high together.
- R9: A start with an all-zero mask gives `done` one cycle after the start is sampled, and no strobe moves.
- R10: `start` is ignored while `busy` is high. A busy run keeps the mask it captured.
- R11: After reset all strobes, selects, memory controls, `busy`, `done` and `fail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled only while idle |
| blk_mask | input | NBLK | Blocks to erase |
| max_tries | input | ATTW | Erase-pulse attempt limit per block |
| t_swe_on | input | CW | Wait after write enable rises |
| t_esu_on | input | CW | Wait after erase setup rises |
| t_pulse | input | CW | Erase pulse width |
| t_pulse_off | input | CW | Wait after erase pulse falls |
| t_esu_off | input | CW | Wait after erase setup falls |
| t_ev_on | input | CW | Wait after verify mode rises |
| t_rd_settle | input | CW | Wait between dummy write and read |
| t_ev_off | input | CW | Wait after verify mode falls |
| t_swe_off | input | CW | Wait after write enable falls |
| mem_rdata | input | DW | Verify read data |
| swe | output | 1 | Software-write enable strobe |
| esu | output | 1 | Erase setup strobe |
| ers | output | 1 | Erase pulse strobe |
| ev | output | 1 | Erase-verify mode strobe |
| wdt_en | output | 1 | Watchdog enable |
| blk_sel | output | NBLK | One-hot block select |
| mem_addr | output | AW | Verify word address |
| mem_wdata | output | DW | Dummy write data |
| mem_we | output | 1 | Dummy write strobe |
| mem_re | output | 1 | Verify read strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
The bound checker watches the strobe relations on every cycle. It checks that the erase pulse is only ever nested inside setup, watchdog and write enable, and that verify mode is kept apart from setup. It also checks that the select stays one-hot, that memory accesses occur only in verify mode and carry the dummy data, and that `done` and `fail` are single-cycle and mutually exclusive. The exact length of every settling interval, the ascending block order, the early exit on the first bad word, the retry count at the limit, and the ignored mid-run start can only be shown by the bench's scenarios. Those scenarios compare each output change and its spacing against a sequence worked out from the requirements.

// File: rtl/fes_pkg.sv
package fes_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SWE_ON,
      ST_SEL,
      ST_WDT_ON,
      ST_ESU_ON,
      ST_ERS_ON,
      ST_ERS_OFF,
      ST_ESU_OFF,
      ST_WDT_OFF,
      ST_EV_ON,
      ST_DUMMY,
      ST_SETTLE,
      ST_READ,
      ST_EV_OFF,
      ST_SWE_OFF,
      ST_END
   } fes_state_e;

   localparam logic [7:0] FES_DUMMY_BYTE = 8'hFF;
endpackage

// File: rtl/fes_timer.sv
module fes_timer #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt > CW'(1))
         cnt <= cnt - CW'(1);
   end

   // a step lasts max(W,1) cycles: it may end once the count is at one or zero
   assign expired = (cnt <= CW'(1));
endmodule

// File: rtl/fes_pick.sv
module fes_pick #(
   parameter int NBLK       = 8,
   parameter bit HIGH_FIRST = 1'b0,
   localparam int IW        = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic [NBLK-1:0] rem,
   output logic [NBLK-1:0] one_hot,
   output logic [IW-1:0]   idx,
   output logic            any
);
   assign any = |rem;

   generate
      if (HIGH_FIRST) begin : g_high
         always_comb begin
            one_hot = '0;
            idx     = '0;
            for (int i = 0; i < NBLK; i++) begin
               if (rem[i]) begin
                  one_hot    = '0;
                  one_hot[i] = 1'b1;
                  idx        = IW'(i);
               end
            end
         end
      end else begin : g_low
         always_comb begin
            one_hot = '0;
            idx     = '0;
            for (int i = NBLK - 1; i >= 0; i--) begin
               if (rem[i]) begin
                  one_hot    = '0;
                  one_hot[i] = 1'b1;
                  idx        = IW'(i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fes_addr_gen.sv
module fes_addr_gen #(
   parameter int AW        = 12,
   parameter int NBLK      = 8,
   parameter int BLK_WORDS = 64,
   localparam int IW       = (NBLK > 1) ? $clog2(NBLK) : 1,
   localparam int OW       = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic [IW-1:0] idx,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          last
);
   logic [AW-1:0] base;
   logic [OW-1:0] off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         off  <= '0;
      end else if (init) begin
         base <= AW'(idx) * AW'(BLK_WORDS);
         off  <= '0;
      end else if (step) begin
         off  <= off + OW'(1);
      end
   end

   assign addr = base + AW'(off);
   assign last = (off == OW'(BLK_WORDS - 1));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import fes_pkg::*;
#(
   parameter int NBLK       = 8,
   parameter int BLK_WORDS  = 64,
   parameter int AW         = 12,
   parameter int DW         = 16,
   parameter int CW         = 24,
   parameter int ATTW       = 8,
   parameter bit HIGH_FIRST = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [NBLK-1:0] blk_mask,
   input  logic [ATTW-1:0] max_tries,
   input  logic [CW-1:0]   t_swe_on,
   input  logic [CW-1:0]   t_esu_on,
   input  logic [CW-1:0]   t_pulse,
   input  logic [CW-1:0]   t_pulse_off,
   input  logic [CW-1:0]   t_esu_off,
   input  logic [CW-1:0]   t_ev_on,
   input  logic [CW-1:0]   t_rd_settle,
   input  logic [CW-1:0]   t_ev_off,
   input  logic [CW-1:0]   t_swe_off,
   input  logic [DW-1:0]   mem_rdata,
   output logic            swe,
   output logic            esu,
   output logic            ers,
   output logic            ev,
   output logic            wdt_en,
   output logic [NBLK-1:0] blk_sel,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic            mem_we,
   output logic            mem_re,
   output logic            busy,
   output logic            done,
   output logic            fail
);
   localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1;

   generate
      if (NBLK < 1) begin : g_bad_nblk
         $error("NBLK must be at least 1");
      end
      if (BLK_WORDS < 1) begin : g_bad_words
         $error("BLK_WORDS must be at least 1");
      end
      if (NBLK * BLK_WORDS > (2 ** AW)) begin : g_bad_aw
         $error("AW too narrow for NBLK*BLK_WORDS words");
      end
      if (DW < 8) begin : g_bad_dw
         $error("DW must be at least 8");
      end
      if (ATTW < 1 || CW < 1) begin : g_bad_cnt
         $error("ATTW and CW must be at least 1");
      end
   endgenerate

   fes_state_e state, nxt;

   logic [NBLK-1:0] rem, cur_sel, pick_oh;
   logic [IW-1:0]   cur_idx, pick_idx;
   logic [ATTW-1:0] tries;
   logic            err, vfail, pick_any;
   logic            t_load, t_exp;
   logic [CW-1:0]   t_val;
   logic            a_init, a_step, a_last;
   logic            rd_ok, tries_spent, sel_on;

   assign rd_ok       = (mem_rdata == {DW{1'b1}});
   assign tries_spent = (tries >= max_tries);

   fes_pick #(.NBLK(NBLK), .HIGH_FIRST(HIGH_FIRST)) u_pick (
      .rem     (rem),
      .one_hot (pick_oh),
      .idx     (pick_idx),
      .any     (pick_any)
   );

   fes_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   fes_addr_gen #(.AW(AW), .NBLK(NBLK), .BLK_WORDS(BLK_WORDS)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (a_init),
      .idx   (cur_idx),
      .step  (a_step),
      .addr  (mem_addr),
      .last  (a_last)
   );

   // next step
   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:    if (start) nxt = (|blk_mask) ? ST_SWE_ON : ST_END;
         ST_SWE_ON:  if (t_exp) nxt = ST_SEL;
         ST_SEL:     nxt = ST_WDT_ON;
         ST_WDT_ON:  nxt = ST_ESU_ON;
         ST_ESU_ON:  if (t_exp) nxt = ST_ERS_ON;
         ST_ERS_ON:  if (t_exp) nxt = ST_ERS_OFF;
         ST_ERS_OFF: if (t_exp) nxt = ST_ESU_OFF;
         ST_ESU_OFF: if (t_exp) nxt = ST_WDT_OFF;
         ST_WDT_OFF: nxt = ST_EV_ON;
         ST_EV_ON:   if (t_exp) nxt = ST_DUMMY;
         ST_DUMMY:   nxt = ST_SETTLE;
         ST_SETTLE:  if (t_exp) nxt = ST_READ;
         ST_READ:    nxt = (!rd_ok || a_last) ? ST_EV_OFF : ST_DUMMY;
         ST_EV_OFF: begin
            if (t_exp) begin
               if (!vfail)
                  nxt = pick_any ? ST_SEL : ST_SWE_OFF;
               else
                  nxt = tries_spent ? ST_SWE_OFF : ST_WDT_ON;
            end
         end
         ST_SWE_OFF: if (t_exp) nxt = ST_END;
         ST_END:     nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   // settling interval of the step about to be entered
   always_comb begin
      case (nxt)
         ST_SWE_ON:  t_val = t_swe_on;
         ST_ESU_ON:  t_val = t_esu_on;
         ST_ERS_ON:  t_val = t_pulse;
         ST_ERS_OFF: t_val = t_pulse_off;
         ST_ESU_OFF: t_val = t_esu_off;
         ST_EV_ON:   t_val = t_ev_on;
         ST_SETTLE:  t_val = t_rd_settle;
         ST_EV_OFF:  t_val = t_ev_off;
         ST_SWE_OFF: t_val = t_swe_off;
         default:    t_val = '0;
      endcase
   end

   assign t_load = (nxt != state);
   assign a_init = (nxt == ST_EV_ON) && (state != ST_EV_ON);
   assign a_step = (state == ST_READ) && (nxt == ST_DUMMY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         rem     <= '0;
         cur_sel <= '0;
         cur_idx <= '0;
         tries   <= '0;
         err     <= 1'b0;
         vfail   <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_IDLE && start) begin
            rem <= blk_mask;
            err <= 1'b0;
         end
         if (nxt == ST_SEL && state != ST_SEL) begin
            cur_sel <= pick_oh;
            cur_idx <= pick_idx;
            rem     <= rem & ~pick_oh;
            tries   <= ATTW'(1);
         end
         if (state == ST_READ)
            vfail <= !rd_ok;
         if (state == ST_EV_OFF && t_exp && vfail) begin
            if (tries_spent)
               err <= 1'b1;
            else
               tries <= tries + ATTW'(1);
         end
      end
   end

   // strobes decoded from the step
   always_comb begin
      swe    = 1'b0;
      esu    = 1'b0;
      ers    = 1'b0;
      ev     = 1'b0;
      wdt_en = 1'b0;
      mem_we = 1'b0;
      mem_re = 1'b0;
      sel_on = 1'b0;
      done   = 1'b0;
      fail   = 1'b0;
      case (state)
         ST_SWE_ON:  swe = 1'b1;
         ST_SEL:     begin swe = 1'b1; sel_on = 1'b1; end
         ST_WDT_ON:  begin swe = 1'b1; sel_on = 1'b1; wdt_en = 1'b1; end
         ST_ESU_ON:  begin swe = 1'b1; sel_on = 1'b1; wdt_en = 1'b1; esu = 1'b1; end
         ST_ERS_ON:  begin swe = 1'b1; sel_on = 1'b1; wdt_en = 1'b1; esu = 1'b1; ers = 1'b1; end
         ST_ERS_OFF: begin swe = 1'b1; sel_on = 1'b1; wdt_en = 1'b1; esu = 1'b1; end
         ST_ESU_OFF: begin swe = 1'b1; sel_on = 1'b1; wdt_en = 1'b1; end
         ST_WDT_OFF: begin swe = 1'b1; sel_on = 1'b1; end
         ST_EV_ON,
         ST_SETTLE:  begin swe = 1'b1; sel_on = 1'b1; ev = 1'b1; end
         ST_DUMMY:   begin swe = 1'b1; sel_on = 1'b1; ev = 1'b1; mem_we = 1'b1; end
         ST_READ:    begin swe = 1'b1; sel_on = 1'b1; ev = 1'b1; mem_re = 1'b1; end
         ST_EV_OFF:  begin swe = 1'b1; sel_on = 1'b1; end
         ST_END:     begin done = !err; fail = err; end
         default:    ;
      endcase
   end

   assign blk_sel   = sel_on ? cur_sel : '0;
   assign mem_wdata = mem_we ? DW'(FES_DUMMY_BYTE) : '0;
   assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/fes_chk.sv
module fes_chk #(
   parameter int NBLK = 8,
   parameter int DW   = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            swe,
   input logic            esu,
   input logic            ers,
   input logic            ev,
   input logic            wdt_en,
   input logic [NBLK-1:0] blk_sel,
   input logic [DW-1:0]   mem_wdata,
   input logic            mem_we,
   input logic            mem_re,
   input logic            busy,
   input logic            done,
   input logic            fail
);
   p_swe_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(swe) |-> (!esu && !ers && !ev && !wdt_en && blk_sel == '0));

   p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(blk_sel));

   p_sel_in_swe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|blk_sel) |-> swe);

   p_ers_nested_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ers |-> (esu && wdt_en && swe && !ev));

   p_esu_wdt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      esu |-> wdt_en);

   p_ev_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev |-> (!esu && !wdt_en));

   p_mem_in_ev_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (ev && !(mem_we && mem_re)));

   p_dummy_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == DW'(8'hFF)));

   p_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |=> !(done || fail));

   p_end_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> (!(done && fail) && !swe && blk_sel == '0 && busy));

   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done && !fail) |=> busy);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!swe && !esu && !ers && !ev && !wdt_en && !mem_we && !mem_re));
endmodule

bind flash_erase_seq fes_chk #(.NBLK(NBLK), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .swe       (swe),
   .esu       (esu),
   .ers       (ers),
   .ev        (ev),
   .wdt_en    (wdt_en),
   .blk_sel   (blk_sel),
   .mem_wdata (mem_wdata),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .busy      (busy),
   .done      (done),
   .fail      (fail)
);

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
   localparam int NB   = 4;
   localparam int BW   = 4;
   localparam int AW   = 6;
   localparam int DW   = 16;
   localparam int CW   = 6;
   localparam int ATTW = 3;
   localparam int VW   = 9 + NB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            start = 1'b0;
   logic [NB-1:0]   blk_mask = '0;
   logic [ATTW-1:0] max_tries = ATTW'(1);
   logic [CW-1:0]   w_x = '0, w_y = '0, w_z = '0, w_a = '0, w_b = '0;
   logic [CW-1:0]   w_g = '0, w_e = '0, w_h = '0, w_t = '0;
   logic [DW-1:0]   m_rdata;
   logic            swe, esu, ers, ev, wdt_en, mem_we, mem_re, busy, done, fail;
   logic [NB-1:0]   blk_sel;
   logic [AW-1:0]   mem_addr;
   logic [DW-1:0]   mem_wdata;

   flash_erase_seq #(.NBLK(NB), .BLK_WORDS(BW), .AW(AW), .DW(DW), .CW(CW), .ATTW(ATTW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .blk_mask(blk_mask), .max_tries(max_tries),
      .t_swe_on(w_x), .t_esu_on(w_y), .t_pulse(w_z), .t_pulse_off(w_a), .t_esu_off(w_b),
      .t_ev_on(w_g), .t_rd_settle(w_e), .t_ev_off(w_h), .t_swe_off(w_t),
      .mem_rdata(m_rdata), .swe(swe), .esu(esu), .ers(ers), .ev(ev), .wdt_en(wdt_en),
      .blk_sel(blk_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .busy(busy), .done(done), .fail(fail)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // flash array model: a block stays unerased at one word until it has had enough pulses
   int need [NB];
   int badw [NB];
   int pcnt [NB];
   logic ers_d = 1'b0;

   always_comb begin
      m_rdata = 16'hFFFF;
      for (int b = 0; b < NB; b++)
         if (pcnt[b] < need[b] && int'(mem_addr) == b * BW + badw[b])
            m_rdata = 16'hFFFE;
   end

   always @(negedge clk) begin
      if (ers && !ers_d)
         for (int b = 0; b < NB; b++)
            if (blk_sel[b]) pcnt[b] = pcnt[b] + 1;
      ers_d = ers;
   end

   // scoreboard
   typedef struct {
      logic [VW-1:0] v;
      int            gap;
      int            addr;
      bit            ca;
      string         req;
   } exp_t;

   exp_t q[$];
   int   prev_dur;

   function automatic logic [VW-1:0] mkv(bit dn, bit fl, bit s, bit e, bit r, bit v,
                                         bit w, bit we, bit re, logic [NB-1:0] sl);
      return {dn, fl, s, e, r, v, w, we, re, sl};
   endfunction

   function automatic int dur(logic [CW-1:0] w);
      return (w < 1) ? 1 : int'(w);
   endfunction

   function automatic void push(logic [VW-1:0] v, int d, int a, bit ca, string req);
      exp_t it;
      it.v = v; it.gap = prev_dur; it.addr = a; it.ca = ca; it.req = req;
      q.push_back(it);
      prev_dur = d;
   endfunction

   // driver side: expected output changes derived from the requirements
   function automatic void plan_run(logic [NB-1:0] mask, int lim);
      bit err = 0;
      prev_dur = -1;
      if (mask == '0) begin
         push(mkv(1,0,0,0,0,0,0,0,0,'0), 1, 0, 0, "R9");
         push(mkv(0,0,0,0,0,0,0,0,0,'0), 1, 0, 0, "R9");
         return;
      end
      push(mkv(0,0,1,0,0,0,0,0,0,'0), dur(w_x), 0, 0, "R1");
      for (int b = 0; b < NB && !err; b++) begin
         logic [NB-1:0] sl;
         int n;
         bit passed;
         if (!mask[b]) continue;
         sl = '0; sl[b] = 1'b1;
         push(mkv(0,0,1,0,0,0,0,0,0,sl), 1, 0, 0, "R2");
         n = 1;
         passed = 0;
         while (!passed && !err) begin
            bit badr = 0;
            push(mkv(0,0,1,0,0,0,1,0,0,sl), 1, 0, 0, "R3");
            push(mkv(0,0,1,1,0,0,1,0,0,sl), dur(w_y), 0, 0, "R3");
            push(mkv(0,0,1,1,1,0,1,0,0,sl), dur(w_z), 0, 0, "R3");
            push(mkv(0,0,1,1,0,0,1,0,0,sl), dur(w_a), 0, 0, "R3");
            push(mkv(0,0,1,0,0,0,1,0,0,sl), dur(w_b), 0, 0, "R3");
            push(mkv(0,0,1,0,0,0,0,0,0,sl), 1, 0, 0, "R3");
            push(mkv(0,0,1,0,0,1,0,0,0,sl), dur(w_g), 0, 0, "R4");
            for (int w = 0; w < BW && !badr; w++) begin
               push(mkv(0,0,1,0,0,1,0,1,0,sl), 1, b * BW + w, 1, "R4");
               push(mkv(0,0,1,0,0,1,0,0,0,sl), dur(w_e), 0, 0, "R4");
               push(mkv(0,0,1,0,0,1,0,0,1,sl), 1, b * BW + w, 1, "R5");
               if (n < need[b] && w == badw[b]) badr = 1;
            end
            push(mkv(0,0,1,0,0,0,0,0,0,sl), dur(w_h), 0, 0, "R6");
            if (!badr) passed = 1;
            else if (n >= lim) err = 1;
            else n++;
         end
      end
      push(mkv(0,0,0,0,0,0,0,0,0,'0), dur(w_t), 0, 0, "R8");
      push(mkv(!err,err,0,0,0,0,0,0,0,'0), 1, 0, 0, err ? "R7" : "R8");
      push(mkv(0,0,0,0,0,0,0,0,0,'0), 1, 0, 0, "R8");
   endfunction

   // monitor side
   logic [VW-1:0] prevv = '0;
   int gapc = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         logic [VW-1:0] cur;
         cur = {done, fail, swe, esu, ers, ev, wdt_en, mem_we, mem_re, blk_sel};
         gapc++;
         if (cur != prevv) begin
            if (q.size() == 0) begin
               chk(0, "R10", "unexpected output change", longint'(cur), longint'(prevv));
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(cur == e.v, e.req, "output vector", longint'(cur), longint'(e.v));
               if (e.gap >= 0)
                  chk(gapc == e.gap, e.req, "cycles before change", gapc, e.gap);
               if (e.ca) begin
                  chk(int'(mem_addr) == e.addr, e.req, "verify address", mem_addr, e.addr);
                  if (mem_we)
                     chk(mem_wdata == 16'h00FF, "R4", "dummy data", mem_wdata, 16'h00FF);
               end
            end
            gapc  = 0;
            prevv = cur;
         end
      end
   end

   task automatic do_run(input logic [NB-1:0] mask, input int lim, input bit poke, input string tag);
      for (int b = 0; b < NB; b++) pcnt[b] = 0;
      max_tries = ATTW'(lim);
      plan_run(mask, lim);
      @(negedge clk);
      blk_mask = mask;
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
      if (poke) begin
         repeat (12) @(negedge clk);
         blk_mask = '1;
         start    = 1'b1;
         @(negedge clk);
         start    = 1'b0;
         blk_mask = mask;
      end
      while (busy) @(negedge clk);
      repeat (5) @(negedge clk);
      chk(q.size() == 0, tag, "expected changes left over", q.size(), 0);
      q.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int b = 0; b < NB; b++) begin need[b] = 1; badw[b] = 0; pcnt[b] = 0; end
      repeat (3) @(negedge clk);
      chk({swe, esu, ers, ev, wdt_en, mem_we, mem_re, busy, done, fail} == '0 && blk_sel == '0,
          "R11", "outputs in reset", {swe, esu, ers, ev, wdt_en, busy, done, fail}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && swe == 1'b0, "R11", "idle after reset", {busy, swe}, 0);

      // R1 R3 R4 R5 R6 R7: two blocks, second needs one retry, bad word is the last one
      w_x = 3; w_y = 2; w_z = 5; w_a = 1; w_b = 0; w_g = 2; w_e = 1; w_h = 2; w_t = 4;
      need[0] = 1; need[2] = 2; badw[2] = BW - 1;
      do_run(4'b0101, 3, 0, "R2");

      // R7 failure after the limit, R10 start ignored mid-run
      need[1] = 5; badw[1] = 0;
      do_run(4'b0010, 2, 1, "R10");

      // R9 empty mask
      do_run(4'b0000, 1, 0, "R9");

      // R1 zero waits act as one cycle, R2 all blocks ascending
      w_x = 0; w_y = 0; w_z = 0; w_a = 0; w_b = 0; w_g = 0; w_e = 0; w_h = 0; w_t = 0;
      for (int b = 0; b < NB; b++) begin need[b] = 1; badw[b] = b; end
      do_run(4'b1111, 1, 0, "R2");

      // R7 pass exactly on the last allowed attempt, bad word in the middle
      w_x = 2; w_y = 1; w_z = 3; w_a = 2; w_b = 2; w_g = 1; w_e = 3; w_h = 1; w_t = 2;
      need[3] = 4; badw[3] = 1;
      do_run(4'b1000, 4, 0, "R7");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule